// File: doc/BRIEF.md
# Auto-Incrementing Indirect Register Port

This block lets a host reach sixteen internal byte registers through only two directly addressed locations: a pointer location and a data window. The host selects a location with a single select line and moves bytes with separate read and write strobes. A write to the pointer location chooses an internal register. Reads and writes of the window then act on that register.

The sixteen internal registers fall into two halves. Indices 0 to 7 are capture registers. They hold received timecode, which comes in from outside, and the host can only read them. Indices 8 to 15 are generator registers. They hold timecode waiting to be transmitted, and the host can only write them.

Bit 7 of the byte written to the pointer location is a mode flag. While it is set, every window access advances the pointer by one, so a block of registers can be transferred in a burst without rewriting the pointer.

Top module: `idx_reg_port`

## Requirements
- R1: After reset the pointer is 0, auto-increment mode is off, every generator byte is 0, and a read of the pointer location returns 0x00.
- R2: A write to the pointer location (host_sel=0) loads the pointer from bits 3..0 and the mode flag from bit 7. Bits 6..4 are ignored. A read of the pointer location returns {mode, 3'b000, pointer}.
- R3: A window read (host_sel=1) at pointer p with p below 8 returns capture byte p, which is cap_bank[8p+7:8p]. The read reflects the current value of cap_bank.
- R4: A window read at a pointer of 8 or above returns 0x00.
- R5: A window write at pointer p with p of 8 or above stores the byte in generator byte p-8, which is gen_bank[8(p-8)+7:8(p-8)]. The stored byte is visible from the next cycle.
- R6: A window write at a pointer below 8 is ignored: gen_bank does not change.
- R7: With the mode flag set, the pointer advances by one after each window read or write. It wraps from 15 to 0.
- R8: With the mode flag clear, window accesses leave the pointer unchanged.
- R9: The mode flag keeps its value through any number of window accesses and pointer reads, until the pointer location is written again.
- R10: Writing 0x80 to the pointer location and then reading the window eight times returns capture bytes 0 through 7 in ascending order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | 0 selects the pointer location, 1 selects the data window |
| host_wr | input | 1 | Write strobe, one access per cycle |
| host_rd | input | 1 | Read strobe, one access per cycle |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for the selected location, valid in the same cycle |
| cap_bank | input | 64 | Capture registers 0..7, byte i at bits 8i+7:8i |
| gen_bank | output | 64 | Generator registers 8..15, byte i-8 at bits 8(i-8)+7:8(i-8) |

## Verification
The assertions are checked on every cycle. They cover how the pointer moves on each access: it loads from a pointer write, steps by one with a 4-bit wrap in auto mode, and holds in manual mode. They also check that the mode flag holds between pointer writes, that writes to capture indices never disturb gen_bank, and that reads of generator indices return zero.

Some behaviour can only be shown by the bench's scenarios, because it depends on sequences of accesses. These are:
- the burst of eight reads that returns the capture bytes in order;
- a burst of writes that fills all eight generator bytes and then wraps the pointer to 0;
- the masking of pointer bits 6..4;
- a read that follows a change of the capture inputs.

// File: rtl/idx_reg_port.sv
module idx_reg_port #(
  parameter int DW = 8,
  parameter int AW = 4,
  localparam int NHALF = (2 ** AW) / 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  host_sel,
  input  logic                  host_wr,
  input  logic                  host_rd,
  input  logic [DW-1:0]         host_wdata,
  output logic [DW-1:0]         host_rdata,
  input  logic [NHALF*DW-1:0]   cap_bank,
  output logic [NHALF*DW-1:0]   gen_bank
);

  logic [AW-1:0] ptr_q;
  logic          auto_q;
  logic [DW-1:0] gen_q [NHALF];

  logic ptr_wr, data_acc, data_wr;
  assign ptr_wr   = host_wr & ~host_sel;
  assign data_acc = host_sel & (host_wr | host_rd);
  assign data_wr  = host_sel & host_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      auto_q <= 1'b0;
    end else if (ptr_wr) begin
      ptr_q  <= host_wdata[AW-1:0];
      auto_q <= host_wdata[DW-1];
    end else if (data_acc && auto_q) begin
      ptr_q  <= ptr_q + 1'b1;
    end
  end

  for (genvar g = 0; g < NHALF; g++) begin : g_gen
    always_ff @(posedge clk) begin
      if (!rst_n)
        gen_q[g] <= '0;
      else if (data_wr && ptr_q[AW-1] && ptr_q[AW-2:0] == g[AW-2:0])
        gen_q[g] <= host_wdata;
    end
    assign gen_bank[g*DW +: DW] = gen_q[g];
  end

  logic [DW-1:0] win_byte, ptr_byte;
  assign win_byte   = ptr_q[AW-1] ? '0 : cap_bank[ptr_q[AW-2:0]*DW +: DW];
  assign ptr_byte   = {auto_q, {(DW-AW-1){1'b0}}, ptr_q};
  assign host_rdata = host_sel ? win_byte : ptr_byte;

  p_addr_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_wr |=> (ptr_q == $past(host_wdata[AW-1:0])) && (auto_q == $past(host_wdata[DW-1])));

  p_wo_read_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (host_sel && ptr_q[AW-1]) |-> host_rdata == '0);

  p_ro_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !ptr_q[AW-1]) |=> $stable(gen_bank));

  p_ptr_inc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && auto_q) |=> ptr_q == $past(ptr_q) + 1'b1);

  p_ptr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && !auto_q) |=> $stable(ptr_q));

  p_mode_latch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ptr_wr |=> $stable(auto_q));

endmodule

// File: tb/tb_idx_reg_port.sv
`timescale 1ns/1ps
module tb_idx_reg_port;
  logic clk = 1'b0, rst_n = 1'b0;
  logic host_sel = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0]  host_wdata = '0, host_rdata;
  logic [63:0] cap_bank, gen_bank;
  logic [7:0]  gen_exp [8];

  int checks = 0, errors = 0, cycles = 0;
  logic [7:0] exp_q [$];
  string      tag_q [$];

  idx_reg_port dut (.clk, .rst_n, .host_sel, .host_wr, .host_rd,
                    .host_wdata, .host_rdata, .cap_bank, .gen_bank);

  always #2.5 clk = ~clk;

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d cycles expected<20000", cycles);
      finish_run();
    end
  end

  // monitor: compares read data mid-cycle against the scoreboard
  always @(negedge clk) begin
    if (host_rd) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL unexpected read: actual=%02h expected=none", host_rdata);
      end else begin
        logic [7:0] e; string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        if (host_rdata !== e) begin
          errors++;
          $display("FAIL %s: actual=%02h expected=%02h", t, host_rdata, e);
        end
      end
    end
  end

  function automatic logic [7:0] cap(int i);
    return cap_bank[i*8 +: 8];
  endfunction

  task automatic drive(input logic sel, input logic wr, input logic rd, input logic [7:0] d);
    @(posedge clk); #1;
    host_sel = sel; host_wr = wr; host_rd = rd; host_wdata = d;
  endtask

  task automatic idle();
    drive(1'b0, 1'b0, 1'b0, 8'h00);
    @(negedge clk);
  endtask

  task automatic wr_ptr(input logic [7:0] d); drive(1'b0, 1'b1, 1'b0, d); endtask
  task automatic wr_win(input logic [7:0] d, input int p);
    if (p >= 8) gen_exp[p-8] = d;
    drive(1'b1, 1'b1, 1'b0, d);
  endtask
  task automatic rd_ptr(input logic [7:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    drive(1'b0, 1'b0, 1'b1, 8'h00);
  endtask
  task automatic rd_win(input logic [7:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    drive(1'b1, 1'b0, 1'b1, 8'h00);
  endtask

  task automatic check_gen(input string t);
    for (int i = 0; i < 8; i++) begin
      checks++;
      if (gen_bank[i*8 +: 8] !== gen_exp[i]) begin
        errors++;
        $display("FAIL %s gen byte %0d: actual=%02h expected=%02h", t, i, gen_bank[i*8 +: 8], gen_exp[i]);
      end
    end
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin
      cap_bank[i*8 +: 8] = 8'hA0 + 8'(i * 3);
      gen_exp[i] = 8'h00;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check_gen("R1 reset");
    rd_ptr(8'h00, "R1 pointer reset");
    rd_win(cap(0), "R1 window at reset pointer");

    wr_ptr(8'h80);
    for (int i = 0; i < 8; i++) rd_win(cap(i), "R10 burst read");
    rd_ptr(8'h88, "R7 pointer after burst");

    for (int k = 0; k < 8; k++) wr_win(8'h11 * 8'(k + 1), 8 + k);
    rd_ptr(8'h80, "R7 wrap 15 to 0");
    idle();
    check_gen("R5 burst write");

    wr_ptr(8'h03);
    rd_win(cap(3), "R8 hold 1");
    rd_win(cap(3), "R8 hold 2");
    rd_win(cap(3), "R8 hold 3");
    rd_ptr(8'h03, "R8 pointer unchanged");

    wr_ptr(8'h72);
    rd_ptr(8'h02, "R2 bits 6..4 masked");
    rd_win(cap(2), "R2 pointer used");

    wr_ptr(8'h05);
    drive(1'b1, 1'b1, 1'b0, 8'hEE);
    idle();
    check_gen("R6 write to capture index");
    rd_win(cap(5), "R6 capture byte intact");

    wr_ptr(8'h0C);
    rd_win(8'h00, "R4 write-only read zero");
    wr_win(8'h5A, 12);
    rd_ptr(8'h0C, "R8 pointer after write");
    idle();
    check_gen("R5 single write");

    wr_ptr(8'h8E);
    rd_ptr(8'h8E, "R9 pointer read keeps mode");
    rd_win(8'h00, "R4 index 14");
    rd_win(8'h00, "R4 index 15");
    rd_ptr(8'h80, "R9 mode kept after wrap");
    rd_win(cap(0), "R7 wrapped to 0");

    wr_ptr(8'h01);
    idle();
    cap_bank[8 +: 8] = 8'h3C;
    rd_win(8'h3C, "R3 live capture value");
    rd_ptr(8'h01, "R9 mode cleared by rewrite");
    idle();

    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard drain: actual=%0d expected=0", exp_q.size());
    end
    finish_run();
  end
endmodule